// File: doc/BRIEF.md
# Dual-Mode Hardware-in-Loop Stream Harness

This block sits between a host link and a streaming design under test (DUT) and decides when the DUT is clocked. In step mode, each full input word that the host sends produces exactly one DUT clock-enable cycle. During that cycle every DUT output lane is captured as one result word, so the host sees a cycle-exact trace. In continuous mode the enable stays high and the DUT runs at full speed. The host then feeds input words, drains result words, and writes or reads registers whenever it likes. Only cycles in which the DUT flags its outputs valid are forwarded, so a sparse stream costs little link bandwidth.

All input lanes move together under one shared valid, and all output lanes move together under one shared valid. Each direction is buffered by a 16-entry queue. The input queue's non-empty state drives the DUT input valid. The output queue's high-water mark drives the DUT output ready. If the DUT is built without an output ready, the high-water mark gates the enable instead. Changing the mode empties both queues and keeps the DUT enable low for one cycle.

Top module: `hil_harness`

## Requirements
- R1: In step mode (mode bit 0), the DUT enable is high for exactly one cycle per input word consumed. A step happens only when the input queue holds a word and the output queue is not full, and `dut_in_valid` is high in every step cycle.
- R2: In step mode, every step pushes one result word equal to `dut_out_data` as sampled in the step cycle, whether or not `dut_out_valid` is high.
- R3: In continuous mode (mode bit 1) with a DUT that has an output ready, `dut_ce` is high in every cycle except the flush cycle.
- R4: Input lane i occupies bits [i*IN_W +: IN_W] of both `h_in_data` and `dut_in_data`. Words reach the DUT in arrival order, each exactly once. In continuous mode `dut_in_valid` is never high while `dut_in_ready` is low.
- R5: In continuous mode a result word is taken only in a cycle with `dut_ce`, `dut_out_valid` and `dut_out_ready` all high. Under any host ready pattern, no result word is lost or repeated.
- R6: `dut_out_ready` is low whenever the output queue holds FIFO_DEPTH-2 (14) or more words. A DUT without output ready is held by `dut_ce` at the same level.
- R7: The control register resets to zero. It changes only on a write to address 1, and `dut_ctrl` always shows its value. Writes to other addresses leave it unchanged.
- R8: A read strobe returns data on `reg_rdata` in the next cycle. Address 0 gives the mode in bit 0, address 1 gives the control register, and address 2 gives `dut_status` as sampled in the strobe cycle.
- R9: A write to address 0 whose bit 0 differs from the current mode starts one flush cycle. In that cycle `dut_ce`, `h_in_ready` and `h_out_valid` are low, and both queues are empty afterwards. A write of the same mode value has no such effect.
- R10: `h_in_ready` is low while the input queue holds 16 words. Outside the flush cycle, `h_out_valid` is high exactly when the output queue holds a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_in_valid | input | 1 | Host input word valid |
| h_in_ready | output | 1 | Harness can take a host input word |
| h_in_data | input | NUM_IN*IN_W | Host input word, all input lanes |
| h_out_valid | output | 1 | Result word available to host |
| h_out_ready | input | 1 | Host takes the result word |
| h_out_data | output | NUM_OUT*OUT_W | Result word, all output lanes |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data, one cycle after strobe |
| dut_ce | output | 1 | DUT clock enable |
| dut_in_valid | output | 1 | Shared valid for all DUT input lanes |
| dut_in_ready | input | 1 | DUT input ready (ignored if HAS_IN_READY=0) |
| dut_in_data | output | NUM_IN*IN_W | DUT input lanes |
| dut_out_valid | input | 1 | Shared valid for all DUT output lanes |
| dut_out_ready | output | 1 | Backpressure to DUT outputs |
| dut_out_data | input | NUM_OUT*OUT_W | DUT output lanes |
| dut_ctrl | output | REG_W | Control register value to DUT |
| dut_status | input | REG_W | DUT status word |

## Verification
A scheduler error in step mode appears within a cycle as an extra or missing `dut_ce` pulse. It also appears as a result trace that is offset by one word from the input sequence. A queue count error shows up when the host ready pattern changes. Result words are then duplicated or missing, or `h_in_ready` and `dut_out_ready` fall at a fill level other than 16 or 14, which the bench measures as an accepted-word total. A stuck mode or flush state is visible in the cycle after the mode write, through `dut_ce` and the host handshakes.

// File: rtl/hil_pkg.sv
package hil_pkg;

    typedef enum logic {
        RUN_STEP = 1'b0,
        RUN_FREE = 1'b1
    } run_mode_e;

    localparam logic [1:0] ADR_MODE = 2'd0;
    localparam logic [1:0] ADR_CTRL = 2'd1;
    localparam logic [1:0] ADR_STAT = 2'd2;

endpackage

// File: rtl/hil_fifo.sv
module hil_fifo #(
    parameter int W        = 16,
    parameter int DEPTH    = 16,
    parameter int AF_LEVEL = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full,
    output logic         almost_full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] count;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    logic [W-1:0] mem [DEPTH];
    logic push_ok, pop_ok;

    assign empty       = (s_q.count == '0);
    assign full        = (s_q.count == CNT_W'(DEPTH));
    assign almost_full = (s_q.count >= CNT_W'(AF_LEVEL));
    assign push_ok     = push && !full && !clear;
    assign pop_ok      = pop && !empty && !clear;
    assign rdata       = mem[s_q.rptr];

    always_comb begin
        s_d = s_q;
        if (clear) begin
            s_d = '0;
        end else begin
            if (push_ok) s_d.wptr = (s_q.wptr == LAST) ? '0 : s_q.wptr + 1'b1;
            if (pop_ok)  s_d.rptr = (s_q.rptr == LAST) ? '0 : s_q.rptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   s_d.count = s_q.count + 1'b1;
                2'b01:   s_d.count = s_q.count - 1'b1;
                default: s_d.count = s_q.count;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[s_q.wptr] <= wdata;
    end

endmodule

// File: rtl/hil_regs.sv
module hil_regs
    import hil_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic             reg_re,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic [REG_W-1:0] status_in,
    output run_mode_e        mode,
    output logic [REG_W-1:0] ctrl,
    output logic             flush,
    output logic [REG_W-1:0] rdata
);
    typedef struct packed {
        run_mode_e        mode;
        logic [REG_W-1:0] ctrl;
        logic             flush;
        logic [REG_W-1:0] rdata;
    } reg_st_t;

    reg_st_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.flush = 1'b0;
        if (reg_we) begin
            case (reg_addr)
                ADR_MODE: begin
                    r_d.mode  = run_mode_e'(reg_wdata[0]);
                    r_d.flush = (reg_wdata[0] != r_q.mode);
                end
                ADR_CTRL: r_d.ctrl = reg_wdata;
                default:  ;
            endcase
        end
        if (reg_re) begin
            case (reg_addr)
                ADR_MODE: r_d.rdata = {{(REG_W-1){1'b0}}, r_q.mode};
                ADR_CTRL: r_d.rdata = r_q.ctrl;
                ADR_STAT: r_d.rdata = status_in;
                default:  r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{mode: RUN_STEP, ctrl: '0, flush: 1'b0, rdata: '0};
        else        r_q <= r_d;
    end

    assign mode  = r_q.mode;
    assign ctrl  = r_q.ctrl;
    assign flush = r_q.flush;
    assign rdata = r_q.rdata;

endmodule

// File: rtl/hil_sched.sv
module hil_sched
    import hil_pkg::*;
#(
    parameter bit HAS_IN_READY  = 1'b1,
    parameter bit HAS_OUT_READY = 1'b1
) (
    input  run_mode_e mode,
    input  logic      flush,
    input  logic      in_empty,
    input  logic      out_full,
    input  logic      out_af,
    input  logic      dut_in_ready,
    input  logic      dut_out_valid,
    output logic      dut_ce,
    output logic      dut_in_valid,
    output logic      dut_out_ready,
    output logic      in_pop,
    output logic      out_push
);
    logic step_go, free_ce, in_ok, out_ok;

    always_comb begin
        step_go = !flush && !in_empty && !out_full;
        free_ce = !flush && (HAS_OUT_READY ? 1'b1 : !out_af);
        in_ok   = HAS_IN_READY ? dut_in_ready : 1'b1;
        out_ok  = !flush && !out_af;

        if (mode == RUN_STEP) begin
            dut_ce        = step_go;
            dut_in_valid  = step_go;
            dut_out_ready = step_go;
            in_pop        = step_go;
            out_push      = step_go;
        end else begin
            dut_ce        = free_ce;
            dut_in_valid  = free_ce && !in_empty && in_ok;
            dut_out_ready = out_ok;
            in_pop        = free_ce && !in_empty && in_ok;
            out_push      = free_ce && dut_out_valid && !out_full &&
                            (HAS_OUT_READY ? out_ok : 1'b1);
        end
    end

endmodule

// File: rtl/hil_harness.sv
module hil_harness
    import hil_pkg::*;
#(
    parameter int NUM_IN        = 2,
    parameter int IN_W          = 8,
    parameter int NUM_OUT       = 2,
    parameter int OUT_W         = 8,
    parameter int REG_W         = 16,
    parameter int FIFO_DEPTH    = 16,
    parameter int AF_MARGIN     = 2,
    parameter bit HAS_IN_READY  = 1'b1,
    parameter bit HAS_OUT_READY = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     h_in_valid,
    output logic                     h_in_ready,
    input  logic [NUM_IN*IN_W-1:0]   h_in_data,
    output logic                     h_out_valid,
    input  logic                     h_out_ready,
    output logic [NUM_OUT*OUT_W-1:0] h_out_data,
    input  logic                     reg_we,
    input  logic                     reg_re,
    input  logic [1:0]               reg_addr,
    input  logic [REG_W-1:0]         reg_wdata,
    output logic [REG_W-1:0]         reg_rdata,
    output logic                     dut_ce,
    output logic                     dut_in_valid,
    input  logic                     dut_in_ready,
    output logic [NUM_IN*IN_W-1:0]   dut_in_data,
    input  logic                     dut_out_valid,
    output logic                     dut_out_ready,
    input  logic [NUM_OUT*OUT_W-1:0] dut_out_data,
    output logic [REG_W-1:0]         dut_ctrl,
    input  logic [REG_W-1:0]         dut_status
);
    localparam int IW       = NUM_IN * IN_W;
    localparam int OW       = NUM_OUT * OUT_W;
    localparam int AF_LEVEL = FIFO_DEPTH - AF_MARGIN;

    run_mode_e mode_w;
    logic      flush_w;
    logic      in_empty, in_full, in_af, in_pop;
    logic      out_empty, out_full, out_af, out_push;

    hil_regs #(.REG_W(REG_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .status_in (dut_status),
        .mode      (mode_w),
        .ctrl      (dut_ctrl),
        .flush     (flush_w),
        .rdata     (reg_rdata)
    );

    assign h_in_ready  = !in_full && !flush_w;
    assign h_out_valid = !out_empty && !flush_w;

    hil_fifo #(.W(IW), .DEPTH(FIFO_DEPTH), .AF_LEVEL(AF_LEVEL)) u_in_q (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (flush_w),
        .push        (h_in_valid && h_in_ready),
        .wdata       (h_in_data),
        .pop         (in_pop),
        .rdata       (dut_in_data),
        .empty       (in_empty),
        .full        (in_full),
        .almost_full (in_af)
    );

    hil_fifo #(.W(OW), .DEPTH(FIFO_DEPTH), .AF_LEVEL(AF_LEVEL)) u_out_q (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (flush_w),
        .push        (out_push),
        .wdata       (dut_out_data),
        .pop         (h_out_valid && h_out_ready),
        .rdata       (h_out_data),
        .empty       (out_empty),
        .full        (out_full),
        .almost_full (out_af)
    );

    hil_sched #(.HAS_IN_READY(HAS_IN_READY), .HAS_OUT_READY(HAS_OUT_READY)) u_sched (
        .mode          (mode_w),
        .flush         (flush_w),
        .in_empty      (in_empty),
        .out_full      (out_full),
        .out_af        (out_af),
        .dut_in_ready  (dut_in_ready),
        .dut_out_valid (dut_out_valid),
        .dut_ce        (dut_ce),
        .dut_in_valid  (dut_in_valid),
        .dut_out_ready (dut_out_ready),
        .in_pop        (in_pop),
        .out_push      (out_push)
    );

    logic unused_w;
    assign unused_w = in_af;

endmodule

// File: rtl/hil_harness_chk.sv
module hil_harness_chk
    import hil_pkg::*;
#(
    parameter int REG_W         = 16,
    parameter int FIFO_DEPTH    = 16,
    parameter bit HAS_IN_READY  = 1'b1,
    parameter bit HAS_OUT_READY = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic             reg_re,
    input logic [1:0]       reg_addr,
    input logic [REG_W-1:0] reg_rdata,
    input logic [REG_W-1:0] dut_status,
    input logic [REG_W-1:0] dut_ctrl,
    input logic             dut_ce,
    input logic             dut_in_valid,
    input logic             dut_in_ready,
    input logic             h_in_valid,
    input logic             h_in_ready,
    input logic             h_out_valid,
    input run_mode_e        mode,
    input logic             flush
);
    localparam int OCC_W = $clog2(FIFO_DEPTH + 1);
    logic [OCC_W-1:0] occ_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     occ_in <= '0;
        else if (flush) occ_in <= '0;
        else            occ_in <= occ_in + OCC_W'(h_in_valid && h_in_ready)
                                         - OCC_W'(dut_in_valid && dut_ce);
    end

    p_step_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == RUN_STEP && dut_ce) |-> dut_in_valid);

    p_free_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_OUT_READY && mode == RUN_FREE && !flush) |-> dut_ce);

    p_in_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_IN_READY && mode == RUN_FREE && dut_in_valid) |-> dut_in_ready);

    p_ctrl_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == ADR_CTRL) |=> $stable(dut_ctrl));

    p_status_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_re && reg_addr == ADR_STAT) |=> (reg_rdata == $past(dut_status)));

    p_flush_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!dut_ce && !h_in_ready && !h_out_valid));

    p_in_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_in == OCC_W'(FIFO_DEPTH)) |-> !h_in_ready);

endmodule

bind hil_harness hil_harness_chk #(
    .REG_W         (REG_W),
    .FIFO_DEPTH    (FIFO_DEPTH),
    .HAS_IN_READY  (HAS_IN_READY),
    .HAS_OUT_READY (HAS_OUT_READY)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_we       (reg_we),
    .reg_re       (reg_re),
    .reg_addr     (reg_addr),
    .reg_rdata    (reg_rdata),
    .dut_status   (dut_status),
    .dut_ctrl     (dut_ctrl),
    .dut_ce       (dut_ce),
    .dut_in_valid (dut_in_valid),
    .dut_in_ready (dut_in_ready),
    .h_in_valid   (h_in_valid),
    .h_in_ready   (h_in_ready),
    .h_out_valid  (h_out_valid),
    .mode         (mode_w),
    .flush        (flush_w)
);

// File: tb/hil_harness_tb.sv
module hil_harness_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_in_valid = 1'b0;
    logic        h_in_ready;
    logic [15:0] h_in_data = '0;
    logic        h_out_valid;
    logic        h_out_ready;
    logic [15:0] h_out_data;
    logic        reg_we = 1'b0, reg_re = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        dut_ce, dut_in_valid, dut_out_ready;
    logic [15:0] dut_in_data;
    logic [15:0] dut_ctrl;
    logic [15:0] dut_status = 16'hA5C3;

    // simple DUT model: one pipeline register adding ctrl[7:0] to each lane
    logic        m_ov;
    logic [15:0] m_od;
    logic        m_in_ready;
    assign m_in_ready = !m_ov || dut_out_ready;

    always #10 clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ov <= 1'b0;
            m_od <= '0;
        end else if (dut_ce && m_in_ready) begin
            m_ov <= dut_in_valid;
            if (dut_in_valid)
                m_od <= {dut_in_data[15:8] + dut_ctrl[7:0], dut_in_data[7:0] + dut_ctrl[7:0]};
        end
    end

    hil_harness u_dut (
        .clk(clk), .rst_n(rst_n),
        .h_in_valid(h_in_valid), .h_in_ready(h_in_ready), .h_in_data(h_in_data),
        .h_out_valid(h_out_valid), .h_out_ready(h_out_ready), .h_out_data(h_out_data),
        .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dut_ce(dut_ce), .dut_in_valid(dut_in_valid), .dut_in_ready(m_in_ready),
        .dut_in_data(dut_in_data), .dut_out_valid(m_ov), .dut_out_ready(dut_out_ready),
        .dut_out_data(m_od), .dut_ctrl(dut_ctrl), .dut_status(dut_status)
    );

    int errors = 0, checks = 0;
    int ngot = 0, ce_cnt = 0, ce_gap = 0, r4_bad = 0;
    bit free_win = 0, rnd_en = 0, rdy_fix = 1;
    logic [15:0] lfsr = 16'hACE1;
    logic [15:0] got [0:127];
    logic [15:0] exp_w [0:127];

    assign h_out_ready = rnd_en ? (lfsr[0] ^ lfsr[5]) : rdy_fix;

    always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

    always @(posedge clk) begin
        if (rst_n) begin
            if (h_out_valid && h_out_ready) begin
                if (ngot < 128) got[ngot] = h_out_data;
                ngot++;
            end
            if (dut_ce) ce_cnt++;
            if (free_win && !dut_ce) ce_gap++;
            if (dut_in_valid && !m_in_ready) r4_bad++;
        end
    end

    function automatic logic [15:0] fx(logic [15:0] w, logic [7:0] c);
        return {w[15:8] + c, w[7:0] + c};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk); reg_we = 0;
    endtask

    task automatic rd(logic [1:0] a, output logic [15:0] d);
        @(negedge clk); reg_re = 1; reg_addr = a;
        @(posedge clk);
        @(negedge clk); reg_re = 0; d = reg_rdata;
    endtask

    task automatic push_one(logic [15:0] d);
        bit done = 0;
        while (!done) begin
            @(negedge clk); h_in_valid = 1; h_in_data = d;
            done = h_in_ready;
            @(posedge clk);
        end
    endtask

    task automatic push_end();
        @(negedge clk); h_in_valid = 0;
    endtask

    task automatic wait_got(int n);
        for (int i = 0; i < 3000 && ngot < n; i++) @(posedge clk);
        repeat (5) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cmp_seq(string req, int n);
        chk(req, ngot, n);
        for (int i = 0; i < n && i < 128; i++) chk(req, got[i], exp_w[i]);
    endtask

    logic [15:0] last_ls;

    task automatic t_reset();
        @(negedge clk);
        chk("R10 reset in_ready", h_in_ready, 1);
        chk("R10 reset out_valid", h_out_valid, 0);
        chk("R1 reset ce", dut_ce, 0);
        chk("R7 reset ctrl", dut_ctrl, 0);
    endtask

    task automatic t_regs();
        logic [15:0] v;
        rd(2'd0, v); chk("R8 mode read", v, 0);
        rd(2'd1, v); chk("R7 ctrl reset read", v, 0);
        wr(2'd1, 16'h0003);
        rd(2'd1, v); chk("R7 ctrl write", v, 16'h0003);
        wr(2'd2, 16'hFFFF);
        chk("R7 ctrl ignores addr 2", dut_ctrl, 16'h0003);
        rd(2'd2, v); chk("R8 status read", v, 16'hA5C3);
        dut_status = 16'h0F0F;
        rd(2'd2, v); chk("R8 status read 2", v, 16'h0F0F);
    endtask

    task automatic t_step_basic();
        ngot = 0; ce_cnt = 0; rdy_fix = 1;
        exp_w[0] = 16'h0000;   // DUT output before first step, valid low (R2)
        for (int k = 0; k < 10; k++) begin
            logic [15:0] w = {8'(k), 8'(8'h10 + k)};
            if (k < 9) exp_w[k+1] = fx(w, 8'h03);
            else last_ls = fx(w, 8'h03);
            push_one(w);
        end
        push_end();
        wait_got(10);
        chk("R1 one ce per step", ce_cnt, 10);
        cmp_seq("R2 step capture", 10);
    endtask

    task automatic t_step_block();
        ngot = 0; ce_cnt = 0; rdy_fix = 0;
        exp_w[0] = last_ls;
        for (int k = 0; k < 20; k++) begin
            logic [15:0] w = {8'(8'h40 + k), 8'(8'h80 + k)};
            if (k < 19) exp_w[k+1] = fx(w, 8'h03);
            else last_ls = fx(w, 8'h03);
            push_one(w);
        end
        push_end();
        repeat (30) @(posedge clk);
        @(negedge clk);
        chk("R1 steps stop at full output", ce_cnt, 16);
        chk("R10 out_valid with words", h_out_valid, 1);
        rdy_fix = 1;
        wait_got(20);
        chk("R1 steps resume", ce_cnt, 20);
        cmp_seq("R2 step capture blocked", 20);
    endtask

    task automatic t_free_stream();
        ngot = 0;
        wr(2'd0, 16'h0001);
        chk("R9 flush ce low", dut_ce, 0);
        chk("R9 flush in_ready low", h_in_ready, 0);
        chk("R9 flush out_valid low", h_out_valid, 0);
        @(negedge clk);
        chk("R3 ce after flush", dut_ce, 1);
        free_win = 1;
        wr(2'd1, 16'h0005);
        rnd_en = 1;
        exp_w[0] = last_ls;
        for (int k = 0; k < 30; k++) begin
            logic [15:0] w = {8'(8'hC0 + k), 8'(3 * k)};
            exp_w[k+1] = fx(w, 8'h05);
            push_one(w);
        end
        push_end();
        wait_got(31);
        rnd_en = 0;
        cmp_seq("R5 free stream order", 31);
        chk("R4 in_valid only with ready", r4_bad, 0);
    endtask

    task automatic t_free_block();
        int acc = 0;
        ngot = 0; rdy_fix = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk); h_in_valid = 1; h_in_data = 16'(k);
            if (h_in_ready) acc++;
            @(posedge clk);
        end
        push_end();
        chk("R10 accepted until full", acc, 31);
        chk("R6 out_ready low at high water", dut_out_ready, 0);
        chk("R10 in_ready low when full", h_in_ready, 0);
        chk("R5 nothing popped", ngot, 0);
        free_win = 0;
        chk("R3 ce never low in free mode", ce_gap, 0);
    endtask

    task automatic t_flush();
        logic [15:0] v;
        wr(2'd0, 16'h0000);
        chk("R9 flush ce low", dut_ce, 0);
        chk("R9 flush out_valid low", h_out_valid, 0);
        chk("R9 flush in_ready low", h_in_ready, 0);
        @(negedge clk);
        chk("R9 out queue empty", h_out_valid, 0);
        chk("R9 in queue empty", h_in_ready, 1);
        rd(2'd0, v); chk("R8 mode read step", v, 0);
        ce_cnt = 0; rdy_fix = 1; ngot = 0;
        wr(2'd0, 16'h0000);
        chk("R9 same mode no flush", h_in_ready, 1);
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R1 no step when empty", ce_cnt, 0);
        chk("R9 flushed words gone", ngot, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        t_reset();
        t_regs();
        t_step_basic();
        t_step_block();
        t_free_stream();
        t_free_block();
        t_flush();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule